// File: doc/BRIEF.md
# Divided-Clock Lock Detector

This block judges whether a serializer's fast bit clock is phase-locked to the parallel word clock that comes with the data. It divides the fast clock by ten to form an internal word-rate clock. At the end of each internal word period it takes one sample of the external reference clock. When the loop is locked, the reference is high at that instant every time. When it is not, the samples come out scattered. The samples pass through a synchronizer and then a small state machine, which turns them into a lock flag. The same flag serves as the output enable of the serial transmitter.

A test-disable input blocks the reference clock so that the oscillator can be trimmed while it free-runs. While that input is high, the lock flag and the output enable are held low. The divided clock is always brought out on a monitor pin, so the free-running frequency can be measured there.

The filter has four named states. DISABLED is held while test-disable is high. ACQUIRE counts consecutive high samples. LOCKED is entered after ACQ_COUNT of them. SLIP is entered after one low sample. Its transitions are:
- DISABLED to ACQUIRE when test-disable is released.
- ACQUIRE to LOCKED on the ACQ_COUNT-th consecutive high sample.
- ACQUIRE back to itself with the count cleared on a low sample.
- LOCKED to SLIP on a low sample.
- SLIP to LOCKED on a high sample.
- SLIP to ACQUIRE on a second low sample.
- Any state to DISABLED while test-disable is high.

Top module: `clkdiv_lock_detector`

## Requirements
- R1: `word_clk_mon` repeats every 10 fast cycles: high for 5 cycles, then low for 5. It is high in the first 5 cycles after reset is released.
- R2: The word tick is the fast edge that ends cycle 10 of each word period, just before `word_clk_mon` rises. At each word tick the block captures `ref_clk` AND NOT `test_disable`. A captured value passes through two more registers that also advance only on ticks. The filter judges it at the third tick after capture.
- R3: In ACQUIRE, the filter enters LOCKED, and `lock_out` goes high, on the 16th consecutive high judged sample.
- R4: In LOCKED, one low judged sample moves the filter to SLIP and `lock_out` stays high. A following high sample returns it to LOCKED.
- R5: In SLIP, a second consecutive low judged sample moves the filter to ACQUIRE, drives `lock_out` low and clears the high count.
- R6: In ACQUIRE, a low judged sample clears the consecutive-high count, so 16 new high samples are needed.
- R7: While `test_disable` is high, `lock_out` is low in that same cycle and the filter is held in DISABLED. Captured samples read as low during that time. After release the filter starts in ACQUIRE with a count of zero.
- R8: `ser_oe` always equals `lock_out`.
- R9: During reset and just after it, `lock_out` and `ser_oe` are low and `word_clk_mon` is high. The sampling registers reset to low.

Filter states: DISABLED, ACQUIRE (the reset state), LOCKED, SLIP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_clk | input | 1 | External parallel reference clock, sampled as data |
| test_disable | input | 1 | Blocks the reference and forces unlock |
| word_clk_mon | output | 1 | Fast clock divided by ten, for monitoring |
| lock_out | output | 1 | Lock flag |
| ser_oe | output | 1 | Serial output enable |

## Verification
The checker assumes that `ref_clk` and `test_disable` change only between fast edges. It also assumes that a fall of `lock_out` with `test_disable` low can only follow a low judged sample at a word tick. The bench drives every input on the falling edge of `clk_fast`. It tracks the word tick with its own counter of fast cycles. It mixes four kinds of reference stimulus: a clean word-rate clock aligned to the tick, a dead low line, random levels from a fixed seed, and short test-disable pulses.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
    typedef enum logic [1:0] {
        LK_DISABLED = 2'd0,
        LK_ACQUIRE  = 2'd1,
        LK_LOCKED   = 2'd2,
        LK_SLIP     = 2'd3
    } lk_state_e;
endpackage

// File: rtl/word_divider.sv
module word_divider #(
    parameter int DIV_RATIO = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic word_tick,
    output logic word_clk
);
    localparam int CW   = $clog2(DIV_RATIO);
    localparam int HALF = DIV_RATIO / 2;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign word_tick = (cnt_q == LAST);
    assign word_clk  = (cnt_q < CW'(HALF));
endmodule

// File: rtl/ref_sampler.sv
module ref_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_tick,
    input  logic ref_in,
    input  logic block,
    output logic judged
);
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pipe_q[0] <= 1'b0;
        else if (word_tick) pipe_q[0] <= ref_in & ~block;
    end

    for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pipe_q[g] <= 1'b0;
            else if (word_tick) pipe_q[g] <= pipe_q[g-1];
        end
    end

    assign judged = pipe_q[SYNC_STAGES];
endmodule

// File: rtl/lock_filter.sv
module lock_filter
    import lockdet_pkg::*;
#(
    parameter int ACQ_COUNT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_tick,
    input  logic judged,
    input  logic force_off,
    output logic locked
);
    localparam int HW = (ACQ_COUNT > 1) ? $clog2(ACQ_COUNT) : 1;
    localparam logic [HW-1:0] HLAST = HW'(ACQ_COUNT - 1);

    lk_state_e     state_q, state_d;
    logic [HW-1:0] hcnt_q, hcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_ACQUIRE;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q;
        if (force_off) begin
            state_d = LK_DISABLED;
            hcnt_d  = '0;
        end else begin
            unique case (state_q)
                LK_DISABLED: begin
                    state_d = LK_ACQUIRE;
                    hcnt_d  = '0;
                end
                LK_ACQUIRE: if (word_tick) begin
                    if (!judged)            hcnt_d = '0;
                    else if (hcnt_q == HLAST) begin
                        state_d = LK_LOCKED;
                        hcnt_d  = '0;
                    end else                hcnt_d = hcnt_q + 1'b1;
                end
                LK_LOCKED: if (word_tick && !judged) state_d = LK_SLIP;
                LK_SLIP: if (word_tick) begin
                    if (judged) state_d = LK_LOCKED;
                    else begin
                        state_d = LK_ACQUIRE;
                        hcnt_d  = '0;
                    end
                end
                default: state_d = LK_ACQUIRE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            LK_LOCKED, LK_SLIP: locked = ~force_off;
            default:            locked = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkdiv_lock_detector.sv
module clkdiv_lock_detector #(
    parameter int DIV_RATIO   = 10,
    parameter int SYNC_STAGES = 2,
    parameter int ACQ_COUNT   = 16
) (
    input  logic clk_fast,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic test_disable,
    output logic word_clk_mon,
    output logic lock_out,
    output logic ser_oe
);
    logic tick;
    logic judged_bit;
    logic lock_int;

    word_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .word_tick (tick),
        .word_clk  (word_clk_mon)
    );

    ref_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .word_tick (tick),
        .ref_in    (ref_clk),
        .block     (test_disable),
        .judged    (judged_bit)
    );

    lock_filter #(.ACQ_COUNT(ACQ_COUNT)) u_flt (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .word_tick (tick),
        .judged    (judged_bit),
        .force_off (test_disable),
        .locked    (lock_int)
    );

    assign lock_out = lock_int;
    assign ser_oe   = lock_int;
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker (
    input logic clk,
    input logic rst_n,
    input logic test_disable,
    input logic mon,
    input logic lock_out,
    input logic ser_oe,
    input logic tick,
    input logic judged
);
    // R1: five cycles high after each rise
    assert_mon_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon) |=> mon ##1 mon ##1 mon ##1 mon ##1 !mon);
    // R1: five cycles low after each fall
    assert_mon_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mon) |=> !mon ##1 !mon ##1 !mon ##1 !mon ##1 mon);
    // R2: the word tick comes just before the monitor rises
    assert_tick_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> $rose(mon));
    // R3: lock rises only after a high judged sample at a tick
    assert_lock_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_out) |-> $past(tick && judged && !test_disable));
    // R5: lock falls without override only after a low judged sample at a tick
    assert_lock_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_out) && !test_disable) |-> $past(tick && !judged));
    // R7: the override keeps lock low through the following cycle
    assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        test_disable |=> !lock_out);
    // R8: the enable follows the lock flag
    assert_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_out) |-> $rose(ser_oe));
endmodule

bind clkdiv_lock_detector lockdet_checker u_chk (
    .clk          (clk_fast),
    .rst_n        (rst_n),
    .test_disable (test_disable),
    .mon          (word_clk_mon),
    .lock_out     (lock_out),
    .ser_oe       (ser_oe),
    .tick         (tick),
    .judged       (judged_bit)
);

// File: tb/test_clkdiv_lock_detector.sv
module test_clkdiv_lock_detector;
    logic clk_fast = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic test_disable = 1'b0;
    logic word_clk_mon, lock_out, ser_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the block, derived from the requirements
    int m_cnt = 0;
    bit m_s0 = 0, m_s1 = 0, m_s2 = 0;
    int m_st = 1;          // 0 disabled, 1 acquire, 2 locked, 3 slip
    int m_h = 0;

    always #2 clk_fast = ~clk_fast;

    clkdiv_lock_detector i_clkdiv_lock_detector (
        .clk_fast     (clk_fast),
        .rst_n        (rst_n),
        .ref_clk      (ref_clk),
        .test_disable (test_disable),
        .word_clk_mon (word_clk_mon),
        .lock_out     (lock_out),
        .ser_oe       (ser_oe)
    );

    function automatic bit exp_lock();
        return ((m_st == 2) || (m_st == 3)) && !test_disable;
    endfunction

    function automatic bit exp_mon();
        return m_cnt < 5;
    endfunction

    task automatic check(input bit act, input bit exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit tk, in;
        tk = (m_cnt == 9);
        in = m_s2;
        if (tk) begin
            m_s2 = m_s1; m_s1 = m_s0; m_s0 = ref_clk & ~test_disable;
        end
        if (test_disable) begin m_st = 0; m_h = 0; end
        else if (m_st == 0) begin m_st = 1; m_h = 0; end
        else if (tk) begin
            case (m_st)
                1: if (!in) m_h = 0;
                   else if (m_h == 15) begin m_st = 2; m_h = 0; end
                   else m_h++;
                2: if (!in) m_st = 3;
                3: if (in) m_st = 2; else begin m_st = 1; m_h = 0; end
                default: m_st = 1;
            endcase
        end
        m_cnt = tk ? 0 : m_cnt + 1;
    endtask

    // mode 0: aligned word clock, 1: dead low, 2: random levels
    task automatic cyc(input int mode, input bit td);
        case (mode)
            0: ref_clk = (m_cnt >= 7) || (m_cnt <= 1);
            1: ref_clk = 1'b0;
            default: ref_clk = 1'($urandom % 2);
        endcase
        test_disable = td;
        @(posedge clk_fast);
        model_edge();
        @(negedge clk_fast);
        check(word_clk_mon, exp_mon(), "R1");
        check(lock_out, exp_lock(), "R3/R4/R5/R6/R7 lock");
        check(ser_oe, lock_out, "R8");
    endtask

    task automatic words(input int n, input int mode, input bit td);
        for (int i = 0; i < n * 10; i++) cyc(mode, td);
    endtask

    initial begin
        void'($urandom(32'd1601));
        repeat (3) @(negedge clk_fast);
        // R9: reset state
        check(lock_out, 1'b0, "R9");
        check(ser_oe, 1'b0, "R9");
        check(word_clk_mon, 1'b1, "R9");
        rst_n = 1'b1;
        // R2/R3: clean reference, lock after 16 judged highs plus latency
        words(25, 0, 0);
        check(lock_out, 1'b1, "R3");
        // R4: one missed sample keeps lock
        words(1, 1, 0);
        words(8, 0, 0);
        check(lock_out, 1'b1, "R4");
        // R5: two missed samples drop lock
        words(2, 1, 0);
        words(3, 0, 0);
        check(lock_out, 1'b0, "R5");
        // R6: 15 highs, a low, then highs again
        words(4, 1, 0);
        words(15, 0, 0);
        words(1, 1, 0);
        words(14, 0, 0);
        check(lock_out, 1'b0, "R6");
        words(10, 0, 0);
        check(lock_out, 1'b1, "R6");
        // R7: override pulse while locked
        words(3, 0, 1);
        check(lock_out, 1'b0, "R7");
        words(10, 0, 0);
        check(lock_out, 1'b0, "R7");
        words(12, 0, 0);
        // R7: short override mid-cycle
        for (int k = 0; k < 20; k++) begin
            cyc(0, 1'($urandom % 7 == 0));
        end
        // random mixes
        for (int r = 0; r < 150; r++) begin
            int m;
            m = $urandom % 4;
            if (m == 3) words(1 + $urandom % 3, 1, 1'($urandom % 5 == 0));
            else if (m == 2) words(1 + $urandom % 4, 2, 0);
            else words(1 + $urandom % 20, 0, 0);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule